// File: doc/BRIEF.md
# Dual Interval Timer Block with Interrupt Flags

This block holds two 16-bit down-counting interval timers behind a byte-wide register bus. The first timer (T1) can either stop raising interrupts after one expiry or reload itself from its latch and keep running. The mode is set by one bit in an auxiliary control register. The second timer (T2) is always one-shot. Each counter steps down by one on every cycle in which the prescale enable input `tick` is high.

A timer is armed, and its interrupt flag cleared, as a side effect of ordinary byte accesses. Writing the low byte only stages the latch. Writing the high byte completes the latch, loads the counter and arms the timer. Reading the low counter byte acknowledges the interrupt. A flag register collects the two timer events and one shift-event flag, which is set from outside through `sr_flag_set`. An enable register masks these flags, and a single level interrupt `irq` is raised while any enabled flag is pending.

Register offsets on `bus_addr`: 0 = T1 counter low, 1 = T1 counter high, 2 = T1 latch low, 3 = T1 latch high, 4 = T2 low, 5 = T2 high, 6 = auxiliary control, 7 = flag register, 8 = enable register. Any other offset reads 0x00. The flag and enable registers use bit 6 for T1, bit 5 for T2 and bit 2 for the shift event. `bus_rdata` is a combinational view of the addressed register. Writes and read side effects take effect at the rising clock edge.

Top module: `via_timers`

## Requirements
- R1: After synchronous reset, the T1 latch, T1 counter, T2 latch and T2 counter are all 0xFFFF. The flag, enable and auxiliary control registers are zero, and `irq` is low.
- R2: A write to offset 4 changes only bits 7:0 of the T2 latch. The T2 counter and the T2 flag (bit 5) are unchanged.
- R3: A write to offset 5 sets T2 latch bits 15:8, loads the whole new latch value into the T2 counter, clears the T2 flag and arms T2, all at the same edge.
- R4: Offset 4 reads T2 counter bits 7:0, and a read there clears the T2 flag at that edge, so `irq` falls one cycle later. Offset 5 reads counter bits 15:8 and leaves the flag alone.
- R5: A counter decrements by one at each edge where `tick` is high, and holds its value otherwise.
- R6: When an armed T2 counter is at 0x0000 and `tick` is high, the counter wraps to 0xFFFF and the T2 flag is set at that edge. The counter then keeps decrementing, but the flag is not set again until offset 5 is written.
- R7: A write to offset 0 or 2 stages T1 latch bits 7:0, and a write to offset 3 stages bits 15:8, without loading the counter. A write to offset 1 sets latch bits 15:8, loads the counter, clears the T1 flag (bit 6) and arms T1. A read of offset 0 returns counter bits 7:0 and clears the T1 flag. Offsets 1, 2 and 3 read counter high, latch low and latch high.
- R8: When auxiliary control bit 6 is 1 (continuous), T1 at 0x0000 with `tick` reloads from its latch and stays armed, so it sets its flag once per latch+1 ticks. When bit 6 is 0 (one-shot), T1 wraps to 0xFFFF and sets no further flag until offset 1 is written again.
- R9: A write to offset 8 with bit 7 = 1 sets the enable bits marked by ones in bits 6:0. With bit 7 = 0 it clears them. Offset 8 reads bit 7 as 1. A write to offset 7 clears the flags marked by ones. Offset 7 reads bit 7 as the OR of all enabled pending flags. A high `sr_flag_set` sets flag bit 2.
- R10: `irq` is high exactly when the flag and enable registers share a set bit among bits 6, 5 and 2.
- R11: If a timer expiry and an acknowledge of the same flag fall on one edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescale enable; counters step on cycles where it is high |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (enables read side effects) |
| bus_rdata | output | 8 | Combinational read data of the addressed register |
| sr_flag_set | input | 1 | Sets the shift-event flag (bit 2) |
| irq | output | 1 | Level interrupt request |

## Verification
Register writes, acknowledge reads and timer expiries all act at the rising edge on which the strobe or `tick` is sampled. Their results therefore appear in `bus_rdata` and `irq` one cycle later, while read data of the current cycle is combinational. The bench's reference model advances at each rising edge from the inputs driven on the preceding falling edge. Every output is compared one nanosecond after the falling edge, by which time both the design and the model hold the post-edge state. Directed sequences use tick bursts of known length, so a wrap or reload lands on a known edge. The read or `irq` check that follows it is placed after that edge.

// File: rtl/via_tmr_pkg.sv
package via_tmr_pkg;

    localparam int CNT_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int FLAG_W  = 7;

    localparam int IRQ_SR  = 2;
    localparam int IRQ_T2  = 5;
    localparam int IRQ_T1  = 6;
    localparam int ACR_T1_CONT = 6;

    localparam logic [FLAG_W-1:0] IRQ_SRC_MASK =
        FLAG_W'((1 << IRQ_T1) | (1 << IRQ_T2) | (1 << IRQ_SR));

    typedef enum logic [ADDR_W-1:0] {
        A_T1_CLO = 4'd0,
        A_T1_CHI = 4'd1,
        A_T1_LLO = 4'd2,
        A_T1_LHI = 4'd3,
        A_T2_LO  = 4'd4,
        A_T2_HI  = 4'd5,
        A_ACR    = 4'd6,
        A_IFR    = 4'd7,
        A_IER    = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic lat_lo_we;
        logic lat_hi_we;
        logic load;
    } tmr_ctl_t;

    function automatic logic [FLAG_W-1:0] ier_next(
        input logic [FLAG_W-1:0] cur,
        input logic [BYTE_W-1:0] wd
    );
        if (wd[BYTE_W-1])
            return cur | wd[FLAG_W-1:0];
        else
            return cur & ~wd[FLAG_W-1:0];
    endfunction

endpackage

// File: rtl/vt_countdown.sv
module vt_countdown
    import via_tmr_pkg::*;
#(
    parameter int W          = CNT_W,
    parameter bit HAS_RELOAD = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  tmr_ctl_t          ctl,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              cont,
    output logic [W-1:0]      count,
    output logic [W-1:0]      latch,
    output logic              expire
);

    logic armed;
    logic at_zero;
    logic reload_go;

    assign at_zero   = (count == '0);
    assign reload_go = HAS_RELOAD & cont;
    assign expire    = armed && tick && at_zero && !ctl.load;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '1;
            latch <= '1;
            armed <= 1'b0;
        end else begin
            if (ctl.lat_lo_we)
                latch[BYTE_W-1:0] <= wdata;
            if (ctl.lat_hi_we || ctl.load)
                latch[W-1:BYTE_W] <= wdata;
            if (ctl.load) begin
                count <= {wdata, latch[BYTE_W-1:0]};
                armed <= 1'b1;
            end else if (tick) begin
                if (at_zero) begin
                    if (reload_go) begin
                        count <= latch;
                    end else begin
                        count <= '1;
                        armed <= 1'b0;
                    end
                end else begin
                    count <= count - W'(1);
                end
            end
        end
    end

    // R3 / R7: high-byte write loads the counter from the completed latch
    a_r3_load_counter: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> count == {$past(wdata), $past(latch[BYTE_W-1:0])});

    // R5: plain decrement away from zero
    a_r5_decrement: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctl.load && count != '0) |=> count == $past(count) - W'(1));

    // R8: continuous reload takes the latch value
    a_r8_reload: assert property (@(posedge clk) disable iff (rst)
        (tick && at_zero && reload_go && !ctl.load) |=> count == $past(latch));

    // R6 / R8: one-shot expiry wraps and disarms
    a_r6_oneshot_wrap: assert property (@(posedge clk) disable iff (rst)
        (expire && !reload_go) |=> (count == '1 && !armed));

    // R5: no tick and no load holds the counter
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ctl.load) |=> $stable(count));

endmodule

// File: rtl/vt_irq_ctrl.sv
module vt_irq_ctrl
    import via_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_W-1:0] set_vec,
    input  logic [FLAG_W-1:0] clr_vec,
    input  logic              ier_we,
    input  logic [BYTE_W-1:0] ier_wdata,
    output logic [FLAG_W-1:0] ifr,
    output logic [FLAG_W-1:0] ier,
    output logic              irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ifr <= '0;
            ier <= '0;
        end else begin
            ifr <= ((ifr & ~clr_vec) | set_vec) & IRQ_SRC_MASK;
            if (ier_we)
                ier <= ier_next(ier, ier_wdata);
        end
    end

    assign irq = |(ifr & ier & IRQ_SRC_MASK);

    // R11: an event raised on an edge is pending after it, acknowledge or not
    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        |(set_vec & IRQ_SRC_MASK) |=> ((ifr & $past(set_vec & IRQ_SRC_MASK)) == $past(set_vec & IRQ_SRC_MASK)));

    // R4: acknowledge of T2 without a coincident expiry leaves it clear
    a_r4_t2_ack: assert property (@(posedge clk) disable iff (rst)
        (clr_vec[IRQ_T2] && !set_vec[IRQ_T2]) |=> !ifr[IRQ_T2]);

    // R10: clearing every enable silences the request
    a_r10_all_masked: assert property (@(posedge clk) disable iff (rst)
        (ier_we && !ier_wdata[BYTE_W-1] && (ier_wdata[FLAG_W-1:0] == '1)) |=> !irq);

endmodule

// File: rtl/via_timers.sv
module via_timers
    import via_tmr_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              sr_flag_set,
    output logic              irq
);

    reg_addr_e         sel;
    tmr_ctl_t          t1_ctl, t2_ctl;
    logic [CW-1:0]     t1_cnt, t1_lat, t2_cnt, t2_lat;
    logic              t1_exp, t2_exp;
    logic [BYTE_W-1:0] acr;
    logic [FLAG_W-1:0] ifr, ier, set_vec, clr_vec;

    assign sel = reg_addr_e'(bus_addr);

    always_comb begin
        t1_ctl.lat_lo_we = bus_we && (sel == A_T1_CLO || sel == A_T1_LLO);
        t1_ctl.lat_hi_we = bus_we && (sel == A_T1_LHI);
        t1_ctl.load      = bus_we && (sel == A_T1_CHI);
        t2_ctl.lat_lo_we = bus_we && (sel == A_T2_LO);
        t2_ctl.lat_hi_we = 1'b0;
        t2_ctl.load      = bus_we && (sel == A_T2_HI);
    end

    vt_countdown #(.W(CW), .HAS_RELOAD(1'b1)) u_t1 (
        .clk(clk), .rst(rst), .tick(tick), .ctl(t1_ctl), .wdata(bus_wdata),
        .cont(acr[ACR_T1_CONT]), .count(t1_cnt), .latch(t1_lat), .expire(t1_exp)
    );

    vt_countdown #(.W(CW), .HAS_RELOAD(1'b0)) u_t2 (
        .clk(clk), .rst(rst), .tick(tick), .ctl(t2_ctl), .wdata(bus_wdata),
        .cont(1'b0), .count(t2_cnt), .latch(t2_lat), .expire(t2_exp)
    );

    always_ff @(posedge clk) begin
        if (rst)
            acr <= '0;
        else if (bus_we && sel == A_ACR)
            acr <= bus_wdata;
    end

    always_comb begin
        set_vec         = '0;
        set_vec[IRQ_SR] = sr_flag_set;
        set_vec[IRQ_T1] = t1_exp;
        set_vec[IRQ_T2] = t2_exp;
        clr_vec         = (bus_we && sel == A_IFR) ? bus_wdata[FLAG_W-1:0] : '0;
        clr_vec[IRQ_T1] = clr_vec[IRQ_T1] | t1_ctl.load | (bus_re && sel == A_T1_CLO);
        clr_vec[IRQ_T2] = clr_vec[IRQ_T2] | t2_ctl.load | (bus_re && sel == A_T2_LO);
    end

    vt_irq_ctrl u_irq (
        .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
        .ier_we(bus_we && sel == A_IER), .ier_wdata(bus_wdata),
        .ifr(ifr), .ier(ier), .irq(irq)
    );

    always_comb begin
        case (sel)
            A_T1_CLO: bus_rdata = t1_cnt[BYTE_W-1:0];
            A_T1_CHI: bus_rdata = t1_cnt[CW-1:BYTE_W];
            A_T1_LLO: bus_rdata = t1_lat[BYTE_W-1:0];
            A_T1_LHI: bus_rdata = t1_lat[CW-1:BYTE_W];
            A_T2_LO:  bus_rdata = t2_cnt[BYTE_W-1:0];
            A_T2_HI:  bus_rdata = t2_cnt[CW-1:BYTE_W];
            A_ACR:    bus_rdata = acr;
            A_IFR:    bus_rdata = {irq, ifr};
            A_IER:    bus_rdata = {1'b1, ier};
            default:  bus_rdata = '0;
        endcase
    end

    // R2: low-byte write stages the T2 latch only and leaves the flag
    a_r2_t2_stage: assert property (@(posedge clk) disable iff (rst)
        (t2_ctl.lat_lo_we && !bus_re && !t2_exp)
            |=> (t2_lat == {$past(t2_lat[CW-1:BYTE_W]), $past(bus_wdata)}
                 && ifr[IRQ_T2] == $past(ifr[IRQ_T2])));

    // R3: high-byte write leaves the T2 flag clear
    a_r3_t2_flag_clear: assert property (@(posedge clk) disable iff (rst)
        t2_ctl.load |=> !ifr[IRQ_T2]);

    // R6: a T2 expiry shows as a pending flag on the next cycle
    a_r6_t2_flag_set: assert property (@(posedge clk) disable iff (rst)
        t2_exp |=> ifr[IRQ_T2]);

    // R1: state right after reset
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (t1_cnt == '1 && t1_lat == '1 && t2_lat == '1 && !irq));

endmodule

// File: tb/via_timers_tb.sv
`timescale 1ns/1ps
module via_timers_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       sr_flag_set = 1'b0;
    logic       irq;

    int n_run = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;

    always #2 clk = ~clk;

    via_timers u_dut (
        .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .sr_flag_set(sr_flag_set), .irq(irq)
    );

    // behavioural reference model
    logic [15:0] m_c1, m_l1, m_c2, m_l2;
    bit          m_a1, m_a2;
    logic [6:0]  m_ifr, m_ier;
    logic [7:0]  m_acr;
    bit ld1, ld2, e1, e2;
    logic [6:0] clr, st;

    always @(posedge clk) begin
        if (rst) begin
            m_c1 = 16'hFFFF; m_l1 = 16'hFFFF; m_c2 = 16'hFFFF; m_l2 = 16'hFFFF;
            m_a1 = 0; m_a2 = 0; m_ifr = 0; m_ier = 0; m_acr = 0;
        end else begin
            ld1 = bus_we && bus_addr == 1;
            ld2 = bus_we && bus_addr == 5;
            e1 = tick && m_c1 == 0 && m_a1 && !ld1;
            e2 = tick && m_c2 == 0 && m_a2 && !ld2;
            clr = 0;
            if (bus_we && bus_addr == 7) clr = bus_wdata[6:0];
            if (ld1 || (bus_re && bus_addr == 0)) clr[6] = 1;
            if (ld2 || (bus_re && bus_addr == 4)) clr[5] = 1;
            st = 0; st[2] = sr_flag_set; st[6] = e1; st[5] = e2;
            // T1
            if (ld1) begin
                m_c1 = {bus_wdata, m_l1[7:0]}; m_a1 = 1;
            end else if (tick) begin
                if (m_c1 == 0) begin
                    if (m_acr[6]) m_c1 = m_l1;
                    else begin m_c1 = 16'hFFFF; m_a1 = 0; end
                end else m_c1 = m_c1 - 1;
            end
            if (bus_we && (bus_addr == 0 || bus_addr == 2)) m_l1[7:0] = bus_wdata;
            if (bus_we && (bus_addr == 1 || bus_addr == 3)) m_l1[15:8] = bus_wdata;
            // T2
            if (ld2) begin
                m_c2 = {bus_wdata, m_l2[7:0]}; m_a2 = 1;
            end else if (tick) begin
                if (m_c2 == 0) begin m_c2 = 16'hFFFF; m_a2 = 0; end
                else m_c2 = m_c2 - 1;
            end
            if (bus_we && bus_addr == 4) m_l2[7:0] = bus_wdata;
            if (ld2) m_l2[15:8] = bus_wdata;
            m_ifr = ((m_ifr & ~clr) | st) & 7'h64;
            if (bus_we && bus_addr == 8)
                m_ier = bus_wdata[7] ? (m_ier | bus_wdata[6:0]) : (m_ier & ~bus_wdata[6:0]);
            if (bus_we && bus_addr == 6) m_acr = bus_wdata;
        end
    end

    function automatic logic m_irq();
        return |(m_ifr & m_ier & 7'h64);
    endfunction

    function automatic logic [7:0] m_rd(input logic [3:0] a);
        case (a)
            0: return m_c1[7:0];
            1: return m_c1[15:8];
            2: return m_l1[7:0];
            3: return m_l1[15:8];
            4: return m_c2[7:0];
            5: return m_c2[15:8];
            6: return m_acr;
            7: return {m_irq(), m_ifr};
            8: return {1'b1, m_ier};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (cmp_on) begin
            chk("R10 irq vs model", {7'd0, irq}, {7'd0, m_irq()});
            if (bus_addr < 4)       chk("R7 rdata vs model", bus_rdata, m_rd(bus_addr));
            else if (bus_addr < 6)  chk("R4 rdata vs model", bus_rdata, m_rd(bus_addr));
            else if (bus_addr == 6) chk("R8 rdata vs model", bus_rdata, m_rd(bus_addr));
            else                    chk("R9 rdata vs model", bus_rdata, m_rd(bus_addr));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_re = 1;
        #1 v = bus_rdata;
        @(negedge clk); bus_re = 0;
    endtask

    task automatic rdchk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1;
        end
        @(negedge clk); tick = 0;
    endtask

    task automatic irqchk(input string tag, input logic exp);
        #1 chk(tag, {7'd0, irq}, {7'd0, exp});
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0; cmp_on = 1;
        // R1 reset values
        rdchk("R1 t1 cnt hi", 1, 8'hFF);
        rdchk("R1 t1 latch hi", 3, 8'hFF);
        rdchk("R1 t2 cnt hi", 5, 8'hFF);
        rdchk("R1 ier", 8, 8'h80);
        rdchk("R1 ifr", 7, 8'h00);
        irqchk("R1 irq low", 0);
        // R2 low byte stages only
        wr(4, 8'h34);
        rdchk("R2 t2 counter unchanged", 4, 8'hFF);
        // R3 high byte loads
        wr(5, 8'h12);
        rdchk("R3 t2 cnt lo", 4, 8'h34);
        rdchk("R3 t2 cnt hi", 5, 8'h12);
        // R6 expiry after 4 ticks from 3
        wr(8, 8'hA0);
        wr(4, 8'h03); wr(5, 8'h00);
        ticks(4);
        irqchk("R6 irq after t2 expiry", 1);
        rdchk("R9 ifr summary", 7, 8'hA0);
        rdchk("R4 hi read keeps flag", 5, 8'hFF);
        irqchk("R4 irq kept after hi read", 1);
        rdchk("R4 lo read", 4, 8'hFF);
        irqchk("R4 irq cleared by lo read", 0);
        ticks(5);
        rdchk("R6 no second flag", 7, 8'h00);
        rdchk("R5 decremented", 4, 8'hFA);
        // R8 continuous T1
        wr(6, 8'h40); wr(0, 8'h02); wr(1, 8'h00);
        wr(8, 8'hC0);
        ticks(3);
        irqchk("R8 t1 continuous expiry", 1);
        rdchk("R8 reloaded from latch", 0, 8'h02);
        rdchk("R7 lo read acknowledged", 7, 8'h00);
        ticks(3);
        rdchk("R8 second continuous expiry", 7, 8'hC0);
        // R8 one-shot T1
        wr(6, 8'h00); wr(1, 8'h00);
        rdchk("R7 load clears flag", 7, 8'h00);
        ticks(3);
        rdchk("R8 one-shot wraps", 1, 8'hFF);
        rdchk("R8 one-shot flag", 7, 8'hC0);
        wr(7, 8'h40);
        rdchk("R9 ifr write clears", 7, 8'h00);
        ticks(3);
        rdchk("R8 one-shot no refire", 7, 8'h00);
        // R9 shift flag and enables
        @(negedge clk); sr_flag_set = 1;
        @(negedge clk); sr_flag_set = 0;
        rdchk("R9 sr flag masked", 7, 8'h04);
        irqchk("R10 masked no irq", 0);
        wr(8, 8'h84);
        irqchk("R10 sr enabled irq", 1);
        rdchk("R9 ifr with sr", 7, 8'h84);
        wr(8, 8'h7F);
        irqchk("R10 all disabled", 0);
        rdchk("R9 ier cleared", 8, 8'h80);
        // R11 expiry and acknowledge on the same edge
        wr(8, 8'hA0);
        wr(4, 8'h01); wr(5, 8'h00);
        ticks(1);
        @(negedge clk); tick = 1; bus_addr = 4; bus_re = 1;
        @(negedge clk); tick = 0; bus_re = 0;
        rdchk("R11 set wins over ack", 7, 8'hA4);
        // random phase checked against the model every cycle
        for (int i = 0; i < 6000; i++) begin
            int op;
            @(negedge clk);
            op = $urandom % 4;
            tick = $urandom % 2;
            sr_flag_set = ($urandom % 32) == 0;
            bus_addr = $urandom % 10;
            bus_wdata = $urandom;
            bus_we = (op == 1);
            bus_re = (op == 2);
            if (bus_we && (bus_addr == 1 || bus_addr == 5))
                bus_wdata = $urandom % 2;
        end
        @(negedge clk); bus_we = 0; bus_re = 0; tick = 0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule